// File: doc/BRIEF.md
# Serial Link Configuration Command Parser

This block sits between a UART receiver and a UART transmitter. It reads the received bytes as text lines that end in LF. It recognises two commands that reconfigure the serial link. The first is `B <rate> <stop>`, which selects the line rate and the number of stop bits. The second is `A <0|1>`, which switches echo off or on. The block checks every argument and answers with a numeric return code written as ASCII digits and followed by CR LF. It drives the rate index, the stop-bit select and the echo flag into the link logic.

A new configuration is held back until the success reply has completely left the transmitter. The host therefore receives the reply at the old rate, and the link changes only after that. While echo is enabled, each received byte is sent straight back to the host, ahead of any reply. The transmitter reports through `tx_idle` that its shift register is empty, and it must lower that signal no later than the cycle after it accepts a byte.

Top module: `serial_cfg_parser`

## Requirements
- R1: After reset `baud_sel` is 0 (the 9600 entry), `two_stop` is 0, `echo_en` is 1 and `tx_valid` is 0.
- R2: Arguments are separated by one or more spaces, CR is ignored and LF ends a line. The line `B <rate> <stop>` with a rate from {9600, 19200, 38400, 57600, 115200, 230400} and a stop value of 1 or 2 is answered with "0" CR LF. It then sets `baud_sel` to the rate's position in that list (0 to 5) and sets `two_stop` to 1 exactly when the stop value is 2.
- R3: A numeric rate that is not in the list, including one that is too large to hold, is answered with "17" CR LF and leaves the settings unchanged. The rate is checked before the stop value.
- R4: A valid rate with a numeric stop value other than 1 or 2 is answered with "18" CR LF and leaves the settings unchanged.
- R5: A new setting changes only in a cycle after one in which `tx_idle` was 1 and `tx_valid` was 0. While the last reply byte is still being serialized, the old settings stay in place.
- R6: The following lines are answered with "3" CR LF and change nothing: a missing argument, a non-digit character inside a numeric argument, an extra argument, an unknown or empty command, or more than one character in the command token.
- R7: `A 0` and `A 1` are answered with "0" CR LF and then clear or set `echo_en`. Any other argument is answered with "3" CR LF.
- R8: While `echo_en` is 1 when a byte arrives, that byte is sent back once, before the reply of the line it ends. While `echo_en` is 0, nothing is sent back.
- R9: A line with more than 32 characters before its LF (CR counted) is answered with "3" CR LF. A line of exactly 32 characters is parsed normally.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_idle | input | 1 | Transmitter has nothing left to send |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Offered byte |
| baud_sel | output | 3 | Rate index, 0 to 5 |
| two_stop | output | 1 | 1 selects two stop bits |
| echo_en | output | 1 | Echo of received bytes enabled |

## Verification
The assertions check on every cycle that the transmit handshake holds its byte and that the rate index stays in range. They also check that a setting never changes unless the transmitter was idle with nothing offered, that every received byte is captured for echo while echo is on, and that only the four defined return codes are ever sent. Whether the decoder gives the right code for a given line can only be seen in the bench's scenarios. The same holds for the ordering of echo against the reply, for the 32/33-character length boundary, and for settings being carried from one command to the next.

// File: rtl/serial_cfg_parser.sv
module serial_cfg_parser #(
  parameter int MAX_LINE = 32,
  parameter int ARG_W    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_ready,
  input  logic       tx_idle,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic [2:0] baud_sel,
  output logic       two_stop,
  output logic       echo_en
);
  localparam int LEN_W = $clog2(MAX_LINE + 2) + 1;
  localparam logic [ARG_W-1:0] ACC_LIM = ARG_W'(((64'd1 << ARG_W) - 64'd10) / 64'd10);
  localparam logic [4:0] RC_OK = 5'd0, RC_PARAM = 5'd3, RC_BAUD = 5'd17, RC_STOP = 5'd18;
  localparam logic [7:0] CH_LF = 8'h0A, CH_CR = 8'h0D, CH_SP = 8'h20;

  typedef enum logic [1:0] {S_IDLE, S_REPLY, S_DRAIN} st_t;
  st_t st;

  logic [1:0]       fidx, cmd;
  logic             in_tok, bad, n1, n2, big1, big2;
  logic [LEN_W-1:0] len_cnt;
  logic [ARG_W-1:0] v1, v2;
  logic [4:0]       rc;
  logic [1:0]       rp_idx;
  logic [2:0]       nb_sel;
  logic             nb_two, ne_en, do_apply;
  logic             echo_pend, out_v, idle_q;
  logic [7:0]       echo_byte, out_d;

  wire is_lf    = rx_valid && rx_data == CH_LF;
  wire is_digit = rx_data >= "0" && rx_data <= "9";
  wire [ARG_W-1:0] dval = ARG_W'(rx_data[3:0]);

  function automatic logic [3:0] rate_lookup(input logic [ARG_W-1:0] v);
    case (32'(v))
      32'd9600:   return 4'b1000;
      32'd19200:  return 4'b1001;
      32'd38400:  return 4'b1010;
      32'd57600:  return 4'b1011;
      32'd115200: return 4'b1100;
      32'd230400: return 4'b1101;
      default:    return 4'b0000;
    endcase
  endfunction

  logic       perr;
  logic [3:0] rl;
  logic [4:0] rc_n;
  always_comb begin
    rl   = rate_lookup(v1);
    perr = bad || len_cnt > LEN_W'(MAX_LINE) || !(cmd == 2'd1 || cmd == 2'd2) || !n1
        || (cmd == 2'd1 && !n2) || (cmd == 2'd2 && (n2 || big1 || v1 > 1));
    if (perr)                                rc_n = RC_PARAM;
    else if (cmd == 2'd2)                    rc_n = RC_OK;
    else if (big1 || !rl[3])                 rc_n = RC_BAUD;
    else if (big2 || (v2 != 1 && v2 != 2))   rc_n = RC_STOP;
    else                                     rc_n = RC_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fidx <= '0; cmd <= '0; in_tok <= 1'b0; bad <= 1'b0; len_cnt <= '0;
      v1 <= '0; v2 <= '0; n1 <= 1'b0; n2 <= 1'b0; big1 <= 1'b0; big2 <= 1'b0;
    end else if (rx_valid) begin
      if (rx_data == CH_LF) begin
        fidx <= '0; cmd <= '0; in_tok <= 1'b0; bad <= 1'b0; len_cnt <= '0;
        v1 <= '0; v2 <= '0; n1 <= 1'b0; n2 <= 1'b0; big1 <= 1'b0; big2 <= 1'b0;
      end else begin
        if (len_cnt != '1) len_cnt <= len_cnt + 1'b1;
        if (rx_data == CH_SP) begin
          if (in_tok && fidx != 2'd3) fidx <= fidx + 1'b1;
          in_tok <= 1'b0;
        end else if (rx_data != CH_CR) begin
          in_tok <= 1'b1;
          case (fidx)
            2'd0: if (in_tok) bad <= 1'b1;
                  else cmd <= (rx_data == "B") ? 2'd1 : (rx_data == "A") ? 2'd2 : 2'd3;
            2'd1: if (!is_digit) bad <= 1'b1;
                  else begin
                    n1 <= 1'b1;
                    if (v1 > ACC_LIM) big1 <= 1'b1;
                    else v1 <= (v1 << 3) + (v1 << 1) + dval;
                  end
            2'd2: if (!is_digit) bad <= 1'b1;
                  else begin
                    n2 <= 1'b1;
                    if (v2 > ACC_LIM) big2 <= 1'b1;
                    else v2 <= (v2 << 3) + (v2 << 1) + dval;
                  end
            default: bad <= 1'b1;
          endcase
        end
      end
    end
  end

  wire       load      = !out_v || tx_ready;
  wire       take_rp   = load && !echo_pend && st == S_REPLY;
  wire [1:0] rp_last   = (rc >= 5'd10) ? 2'd3 : 2'd2;
  logic [7:0] rp_byte;
  always_comb begin
    if (rc >= 5'd10)
      case (rp_idx)
        2'd0: rp_byte = "1";
        2'd1: rp_byte = 8'("0") + 8'(rc - 5'd10);
        2'd2: rp_byte = CH_CR;
        default: rp_byte = CH_LF;
      endcase
    else
      case (rp_idx)
        2'd0: rp_byte = 8'("0") + 8'(rc);
        2'd1: rp_byte = CH_CR;
        default: rp_byte = CH_LF;
      endcase
  end

  wire apply = st == S_DRAIN && idle_q && tx_idle && !out_v && !echo_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rc <= RC_OK; rp_idx <= '0; do_apply <= 1'b0;
      nb_sel <= '0; nb_two <= 1'b0; ne_en <= 1'b1;
      baud_sel <= '0; two_stop <= 1'b0; echo_en <= 1'b1;
      echo_pend <= 1'b0; echo_byte <= '0; out_v <= 1'b0; out_d <= '0; idle_q <= 1'b0;
    end else begin
      idle_q <= tx_idle && !out_v;
      if (rx_valid && echo_en) begin
        echo_pend <= 1'b1;
        echo_byte <= rx_data;
      end else if (load) echo_pend <= 1'b0;
      if (load) begin
        out_v <= echo_pend || st == S_REPLY;
        out_d <= echo_pend ? echo_byte : rp_byte;
      end
      case (st)
        S_IDLE: if (is_lf) begin
          st <= S_REPLY; rc <= rc_n; rp_idx <= '0;
          do_apply <= rc_n == RC_OK;
          nb_sel   <= (cmd == 2'd1) ? rl[2:0] : baud_sel;
          nb_two   <= (cmd == 2'd1) ? v2 == 2 : two_stop;
          ne_en    <= (cmd == 2'd2) ? v1[0] : echo_en;
        end
        S_REPLY: if (take_rp) begin
          rp_idx <= rp_idx + 1'b1;
          if (rp_idx == rp_last) st <= do_apply ? S_DRAIN : S_IDLE;
        end
        default: if (apply) begin
          baud_sel <= nb_sel; two_stop <= nb_two; echo_en <= ne_en;
          st <= S_IDLE;
        end
      endcase
    end
  end

  assign tx_valid = out_v;
  assign tx_data  = out_d;

  p_apply_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({baud_sel, two_stop, echo_en}) |-> $past(tx_idle) && !$past(tx_valid));
  p_baud_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    baud_sel <= 3'd5);
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  p_echo_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && echo_en |=> echo_pend && echo_byte == $past(rx_data));
  p_reply_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_REPLY |-> (rc == RC_OK || rc == RC_PARAM || rc == RC_BAUD || rc == RC_STOP));
endmodule

// File: tb/serial_cfg_parser_tb.sv
module serial_cfg_parser_tb_top;
  localparam int BUSY = 20;
  localparam int GAP  = 30;
  localparam int NV   = 17;

  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_ready, tx_idle, tx_valid, two_stop, echo_en;
  logic [7:0] tx_data;
  logic [2:0] baud_sel;

  always #4 clk = ~clk;

  serial_cfg_parser dut_i (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_idle(tx_idle), .tx_valid(tx_valid), .tx_data(tx_data),
    .baud_sel(baud_sel), .two_stop(two_stop), .echo_en(echo_en));

  int busy;
  int cap_n;
  logic [7:0] cap [512];
  assign tx_ready = busy == 0;
  assign tx_idle  = busy == 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 0; cap_n <= 0;
    end else if (tx_valid && tx_ready) begin
      cap[cap_n % 512] <= tx_data; cap_n <= cap_n + 1; busy <= BUSY;
    end else if (busy != 0) busy <= busy - 1;
  end

  localparam logic [127:0] V_STR [NV] = '{
    "B 57600 1", "B 1200 1", "B 19200 3", "B 1234 5", "B 9600", "B 96x0 1",
    "B 999999 2", "B 230400 2", "A 2", "X 1", "BB 9600 1", "B 115200 1 5",
    "A 0", "B  38400  2", "A 1", "B 19200 1", ""};
  localparam int V_CODE [NV] = '{0, 17, 18, 17, 3, 3, 17, 0, 3, 3, 3, 3, 0, 0, 0, 0, 3};
  localparam int V_BAUD [NV] = '{3, 3, 3, 3, 3, 3, 3, 5, 5, 5, 5, 5, 5, 2, 2, 1, 1};
  localparam int V_TWO  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0};
  localparam int V_ECHO [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1};
  localparam logic [23:0] V_TAG [NV] = '{"R2", "R3", "R4", "R3", "R6", "R6", "R3", "R2",
    "R7", "R6", "R6", "R6", "R7", "R2", "R8", "R2", "R6"};

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] lbuf [64];
  int llen;
  logic cur_echo = 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int got, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic run_buf(input int code, input int eb, input int et, input int ee, input string tag);
    int base, target, rlen, nech, ob, ot, oe;
    logic [7:0] rexp [4];
    logic ok;
    base = cap_n; ob = baud_sel; ot = two_stop; oe = echo_en;
    lbuf[llen] = 8'h0D; lbuf[llen+1] = 8'h0A;
    nech = cur_echo ? llen + 2 : 0;
    if (code >= 10) begin
      rexp[0] = "1"; rexp[1] = 8'("0" + code - 10); rexp[2] = 8'h0D; rexp[3] = 8'h0A; rlen = 4;
    end else begin
      rexp[0] = 8'("0" + code); rexp[1] = 8'h0D; rexp[2] = 8'h0A; rlen = 3;
    end
    target = base + nech + rlen;
    for (int i = 0; i < llen + 2; i++) send_byte(lbuf[i]);
    for (int w = 0; w < 3000 && cap_n < target; w++) @(negedge clk);
    // R5: reply just accepted, transmitter still busy, old settings in place
    check(busy != 0 && baud_sel == ob[2:0] && two_stop == ot[0] && echo_en == oe[0],
          {tag, " R5 hold"}, int'(baud_sel), ob);
    repeat (60) @(negedge clk);
    ok = 1'b1;
    for (int i = 0; i < nech; i++) if (cap[(base + i) % 512] != lbuf[i]) ok = 1'b0;
    check(ok && cap_n >= base + nech, {tag, " R8 echo"}, cap_n - base, nech);
    ok = cap_n == target;
    for (int i = 0; i < rlen; i++) if (cap[(base + nech + i) % 512] != rexp[i]) ok = 1'b0;
    check(ok, {tag, " reply"}, int'(cap[(base + nech) % 512]), int'(rexp[0]));
    check(baud_sel == eb[2:0] && two_stop == et[0] && echo_en == ee[0], {tag, " settings"},
          int'({baud_sel, two_stop, echo_en}), (eb << 2) | (et << 1) | ee);
    cur_echo = ee[0];
  endtask

  task automatic run_str(input logic [127:0] s, input int code, input int eb, input int et,
                         input int ee, input string tag);
    llen = 0;
    for (int k = 0; k < 16; k++) if (s[8*k +: 8] != 0) llen = llen + 1;
    for (int i = 0; i < llen; i++) lbuf[i] = s[8*(llen-1-i) +: 8];
    run_buf(code, eb, et, ee, tag);
  endtask

  task automatic run_padded(input int nsp, input int code, input int eb, input int et, input string tag);
    llen = 0;
    lbuf[llen++] = "B";
    for (int i = 0; i < nsp; i++) lbuf[llen++] = " ";
    lbuf[llen++] = "9"; lbuf[llen++] = "6"; lbuf[llen++] = "0"; lbuf[llen++] = "0";
    lbuf[llen++] = " "; lbuf[llen++] = "1";
    run_buf(code, eb, et, 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(baud_sel == 0 && two_stop == 0 && echo_en == 1 && tx_valid == 0, "R1 in reset",
          int'({baud_sel, two_stop, echo_en, tx_valid}), 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(baud_sel == 0 && two_stop == 0 && echo_en == 1 && tx_valid == 0, "R1 after reset",
          int'({baud_sel, two_stop, echo_en, tx_valid}), 2);
    for (int v = 0; v < NV; v++)
      run_str(V_STR[v], V_CODE[v], V_BAUD[v], V_TWO[v], V_ECHO[v], $sformatf("%s", V_TAG[v]));
    run_padded(24, 0, 0, 0, "R9 32 chars");
    run_str("B 57600 2", 0, 3, 1, 1, "R2");
    run_padded(25, 3, 3, 1, "R9 33 chars");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(baud_sel == 0 && two_stop == 0 && echo_en == 1 && tx_valid == 0, "R1 re-reset",
          int'({baud_sel, two_stop, echo_en, tx_valid}), 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule